// File: doc/BRIEF.md
# Framed Serial Message Receiver

This block takes the receive line of an asynchronous serial link, such as a radio modem, and recovers bytes sent as one start bit, eight data bits with the least significant bit first, no parity and one stop bit. A free-running divider gives a sampling tick at sixteen times the bit rate. The divider is an integer parameter: system clock over (bit rate × 16). A low level on the idle line is confirmed half a bit later. Each data bit and the stop bit are then taken at their middle.

Recovered bytes go through a framing filter. A start character clears the message buffer and opens a message. The bytes that follow are stored until the terminate character closes the message. Only a message with both delimiters is released. On release a one-cycle flag goes to the downstream controller, and the stored length becomes visible. The controller reads the payload through a byte-indexed read port. The length and the payload stay readable until the next start character.

The line is a plain serial input and cannot be stalled, so the block has no back-pressure. A message that arrives while the controller is still reading replaces the old one only from its start character onward. The read port is a plain random-access port with no handshake.

Top module: `frame_filter_rx`

## Requirements
- R1: A byte sent as a low start bit, eight data bits least significant bit first and a high stop bit, with sixteen sampling ticks of TICK_DIV clocks per bit, is recovered with its exact value for every bit pattern.
- R2: A low pulse on the idle line that has ended by the start-bit confirmation point, eight ticks after it is seen, is rejected. No byte is produced, and a byte that follows is recovered normally.
- R3: A byte whose stop bit is low at mid-bit is dropped and never reaches the message buffer.
- R4: Bytes that arrive while no message is open are ignored, including a lone terminate character. msg_len and rd_data do not change.
- R5: A start character (default 8'h02) clears the message: msg_len becomes 0 and rd_data reads 0 at every index. A start character inside an open message restarts it.
- R6: The terminate character (default 8'h03) in an open message raises msg_received for exactly one clock cycle. At that point msg_len equals the number of payload bytes stored, and rd_data at index i returns the i-th payload byte, counted from 0. An empty message gives a pulse with length 0.
- R7: A message that lacks its start character or its terminate character never raises msg_received.
- R8: A message of exactly DEPTH payload bytes is released. A message with more than DEPTH payload bytes is discarded without a pulse: msg_len stays 0, and nothing is stored until the next start character.
- R9: After a release, msg_len and the buffer contents stay unchanged until the next start character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial receive line, idle high |
| rd_idx | input | $clog2(DEPTH) | Byte index into the released message |
| rd_data | output | 8 | Payload byte at rd_idx, or 0 at or beyond msg_len |
| msg_received | output | 1 | One-cycle pulse when a framed message completes |
| msg_len | output | $clog2(DEPTH+1) | Payload length of the last released message, 0 after a start character |

## Verification
Two decisions can fall on the same byte. The terminate character can arrive just as the buffer holds exactly DEPTH bytes. It must then complete the message and not count as an overflow. One more payload byte must instead tip the message into a discard. The bench sends a full-length message and then a message one byte longer, each closed by the terminate character. It judges the first by a released length of DEPTH with every byte read back, and the second by the absence of any pulse and a length of 0. A start character arriving inside an open message is also provoked, to show that the restart wins over storing.

// File: rtl/uartf_pkg.sv
package uartf_pkg;
  localparam int BYTE_W = 8;
  localparam int OVS = 16;
  localparam int OVS_W = $clog2(OVS);
  localparam int HALF_TICK = OVS / 2 - 1;
  localparam int LAST_TICK = OVS - 1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/uartf_tick_gen.sv
module uartf_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(TICK_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: ticks are spaced TICK_DIV clocks apart
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (TICK_DIV > 1)) |=> !tick);
endmodule

// File: rtl/uartf_byte_rx.sv
module uartf_byte_rx
  import uartf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [1:0]        sync;
  logic              rx_s;
  rx_state_t         state;
  logic [OVS_W-1:0]  cnt;
  logic [BIT_W-1:0]  nbit;
  logic [BYTE_W-1:0] shreg;

  assign rx_s      = sync[1];
  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync       <= 2'b11;
      state      <= RX_IDLE;
      cnt        <= '0;
      nbit       <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
    end else begin
      sync       <= {sync[0], rx};
      byte_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rx_s) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == OVS_W'(HALF_TICK)) begin
              cnt <= '0;
              if (!rx_s) begin
                state <= RX_DATA;
                nbit  <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt == OVS_W'(LAST_TICK)) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[BYTE_W-1:1]};
              nbit  <= nbit + 1'b1;
              if (nbit == BIT_W'(BYTE_W - 1)) state <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == OVS_W'(LAST_TICK)) begin
              cnt        <= '0;
              byte_valid <= rx_s;
              state      <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R1: a recovered byte is a single strobe, issued on the way back to idle
  p_byte_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  p_byte_at_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (state == RX_IDLE));
endmodule

// File: rtl/uartf_frame_buf.sv
module uartf_frame_buf
  import uartf_pkg::*;
#(
  parameter int              DEPTH      = 16,
  parameter logic [BYTE_W-1:0] START_CHAR = 8'h02,
  parameter logic [BYTE_W-1:0] END_CHAR   = 8'h03
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_valid,
  input  logic [BYTE_W-1:0]          byte_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic                       msg_received,
  output logic [$clog2(DEPTH+1)-1:0] msg_len
);
  localparam int LENW = $clog2(DEPTH + 1);
  localparam int IDXW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [LENW-1:0]   fill;
  logic              storing;
  logic              is_start, is_end, full, wr_en;

  assign is_start = byte_valid && (byte_data == START_CHAR);
  assign is_end   = byte_valid && (byte_data == END_CHAR);
  assign full     = (fill == LENW'(DEPTH));
  assign wr_en    = byte_valid && storing && !is_start && !is_end && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill         <= '0;
      storing      <= 1'b0;
      msg_len      <= '0;
      msg_received <= 1'b0;
    end else begin
      msg_received <= 1'b0;
      if (is_start) begin
        fill    <= '0;
        storing <= 1'b1;
        msg_len <= '0;
      end else if (storing && is_end) begin
        storing      <= 1'b0;
        msg_len      <= fill;
        msg_received <= 1'b1;
      end else if (storing && byte_valid && full) begin
        storing <= 1'b0;
      end else if (wr_en) begin
        fill <= fill + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[fill[IDXW-1:0]] <= byte_data;
  end

  always_comb begin
    if (LENW'(rd_idx) < msg_len) rd_data = mem[rd_idx];
    else                         rd_data = '0;
  end

  // R6: release flag lasts one cycle
  p_msg_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_received |=> !msg_received);
  // R8: counts never pass the buffer depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= LENW'(DEPTH)) && (msg_len <= LENW'(DEPTH)));
  // R9: length changes only on release or on a clearing start character
  p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msg_len) |-> (msg_received || (msg_len == '0)));
endmodule

// File: rtl/frame_filter_rx.sv
module frame_filter_rx
  import uartf_pkg::*;
#(
  parameter int                TICK_DIV   = 4,
  parameter int                DEPTH      = 16,
  parameter logic [BYTE_W-1:0] START_CHAR = 8'h02,
  parameter logic [BYTE_W-1:0] END_CHAR   = 8'h03
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic                       msg_received,
  output logic [$clog2(DEPTH+1)-1:0] msg_len
);
  logic              tick;
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;

  uartf_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  uartf_byte_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rx        (rx),
    .byte_data (byte_data),
    .byte_valid(byte_valid)
  );

  uartf_frame_buf #(
    .DEPTH     (DEPTH),
    .START_CHAR(START_CHAR),
    .END_CHAR  (END_CHAR)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .msg_received(msg_received),
    .msg_len     (msg_len)
  );
endmodule

// File: tb/tb_frame_filter_rx.sv
module tb_frame_filter_rx;
  localparam int TICK_DIV = 4;
  localparam int DEPTH = 16;
  localparam int BIT = 16 * TICK_DIV;
  localparam logic [7:0] SC = 8'h02;
  localparam logic [7:0] EC = 8'h03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       msg_received;
  logic [4:0] msg_len;

  int tests = 0;
  int failed = 0;
  int pulses = 0;
  int sent_msgs = 0;
  int exp_len[$];
  logic [7:0] exp_bytes[$];
  logic [7:0] pl[$];

  always #2 clk = ~clk;

  frame_filter_rx #(.TICK_DIV(TICK_DIV), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .rd_idx(rd_idx),
    .rd_data(rd_data), .msg_received(msg_received), .msg_len(msg_len)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic peek(input int idx, output logic [7:0] val);
    rd_idx = 4'(idx);
    #1;
    val = rd_data;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    if (stop_ok) begin
      rx = 1'b1;
      repeat (BIT) @(negedge clk);
    end else begin
      rx = 1'b0;
      repeat (11 * TICK_DIV) @(negedge clk);
      rx = 1'b1;
      repeat (BIT) @(negedge clk);
    end
    repeat (2 * TICK_DIV) @(negedge clk);
  endtask

  task automatic send_glitch();
    @(negedge clk);
    rx = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  // driver: queue the expected message, then send it framed
  task automatic send_expected();
    exp_len.push_back(pl.size());
    foreach (pl[i]) exp_bytes.push_back(pl[i]);
    sent_msgs++;
    send_byte(SC, 1'b1);
    foreach (pl[i]) send_byte(pl[i], 1'b1);
    send_byte(EC, 1'b1);
  endtask

  // monitor: compare each release against the scoreboard
  initial begin
    logic [7:0] v;
    forever begin
      @(negedge clk);
      if (rst_n && msg_received) begin
        pulses++;
        if (exp_len.size() == 0) begin
          check("R7 unexpected release", 1, 0);
        end else begin
          int n;
          n = exp_len.pop_front();
          check("R6 released length", int'(msg_len), n);
          for (int i = 0; i < n; i++) begin
            peek(i, v);
            check("R6 R1 payload byte", int'(v), int'(exp_bytes.pop_front()));
          end
          @(negedge clk);
          check("R6 single-cycle pulse", int'(msg_received), 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    check("reset msg_received", int'(msg_received), 0);
    check("reset msg_len", int'(msg_len), 0);
    peek(0, v);
    check("reset rd_data", int'(v), 0);
    rst_n = 1'b1;
    repeat (3 * BIT) @(negedge clk);

    // R1 R6: basic framed message
    pl = '{8'h48, 8'h69};
    send_expected();
    repeat (BIT) @(negedge clk);

    // R4 R9: bytes outside a message leave the last release intact
    send_byte(8'h5A, 1'b1);
    send_byte(EC, 1'b1);
    send_byte(8'h55, 1'b1);
    check("R4 msg_len after stray bytes", int'(msg_len), 2);
    peek(1, v);
    check("R9 held payload byte", int'(v), 8'h69);

    // R5 R7: start clears; open message restarted by a new start
    send_byte(SC, 1'b1);
    check("R5 msg_len cleared on start", int'(msg_len), 0);
    peek(0, v);
    check("R5 buffer cleared on start", int'(v), 0);
    send_byte(8'h61, 1'b1);
    send_byte(8'h62, 1'b1);
    pl = '{8'h63};
    send_expected();
    repeat (BIT) @(negedge clk);

    // R7: terminate without a start character
    send_byte(8'h71, 1'b1);
    send_byte(EC, 1'b1);
    check("R7 no release without start", int'(msg_len), 1);

    // R2: short low pulse inside a message is rejected
    exp_len.push_back(2);
    exp_bytes.push_back(8'h41);
    exp_bytes.push_back(8'h42);
    sent_msgs++;
    send_byte(SC, 1'b1);
    send_byte(8'h41, 1'b1);
    send_glitch();
    send_byte(8'h42, 1'b1);
    send_byte(EC, 1'b1);
    repeat (BIT) @(negedge clk);

    // R3: byte with low stop bit is dropped
    exp_len.push_back(1);
    exp_bytes.push_back(8'h59);
    sent_msgs++;
    send_byte(SC, 1'b1);
    send_byte(8'h58, 1'b0);
    send_byte(8'h59, 1'b1);
    send_byte(EC, 1'b1);
    repeat (BIT) @(negedge clk);

    // R8: exactly DEPTH payload bytes completes
    pl = {};
    for (int i = 0; i < DEPTH; i++) pl.push_back(8'(8'h10 + i * 7));
    send_expected();
    repeat (BIT) @(negedge clk);
    check("R8 full-length release", int'(msg_len), DEPTH);

    // R8: DEPTH+1 payload bytes is discarded
    send_byte(SC, 1'b1);
    for (int i = 0; i <= DEPTH; i++) send_byte(8'(8'h20 + i), 1'b1);
    send_byte(EC, 1'b1);
    check("R8 overflow discarded length", int'(msg_len), 0);
    peek(0, v);
    check("R8 overflow leaves nothing readable", int'(v), 0);

    // R6: empty message
    pl = {};
    send_expected();
    repeat (BIT) @(negedge clk);

    // R1: assorted bit patterns, LSB first
    pl = '{8'h80, 8'h01, 8'hA5, 8'hFF, 8'h00, 8'h5C};
    send_expected();
    repeat (2 * BIT) @(negedge clk);

    check("R7 all expected messages released", exp_len.size(), 0);
    check("R7 release count", pulses, sent_msgs);
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule